// File: doc/BRIEF.md
# Write-Status Polling Word Generator

This block builds the word a parallel NOR-style flash places on its data bus when the host reads during an internal program or erase. While the operation is busy, the word carries two status flags in fixed bit positions. One is a polarity flag that tells the host whether the operation has finished. The other is a flag that changes on each separate read. Once the operation is idle, the block passes the addressed location's true data through unchanged.

The surrounding controller does three things:
- It pulses `op_start` with the operation kind and the word being programmed on the cycle its final command write strobe completes. That is the fourth strobe for a word program and the sixth for any erase.
- It holds `busy` high for as long as the array operation runs.
- It presents the addressed array word on `array_word`.

Each rising edge of the read enable produces one registered output word, flagged by a one-cycle `rd_valid`.

Top module: `write_status_poll`

## Requirements
- R1: While busy with a program (`op_kind` = 0 at start), bit 7 of a read word is the complement of bit 7 of the word being programmed. All other bits except bit 6 are taken from `array_word`.
- R2: While busy with an erase (`op_kind` = 1 at start), bit 7 of a read word is 0. All other bits except bit 6 are 1.
- R3: While busy, bit 6 alternates between reads. The first read after `op_start` returns 0, the second returns 1, and so on, so the first two status reads always differ.
- R4: Holding `rd_en` high for many cycles counts as one read. The toggle flag advances once per rising edge of `rd_en`, never once per clock.
- R5: While `busy` is low, a read returns `array_word` unchanged, including bits 7 and 6. After an erase completes, bit 7 of an erased (all ones) location therefore reads 1.
- R6: `rd_data` loads one clock after the cycle in which a rising edge of `rd_en` is seen, and holds its value at all other times. After reset, `rd_data` is 0 and `rd_valid` is 0.
- R7: `op_start` captures the operation kind and the programmed word and clears the toggle flag, even in the middle of a busy period. Changes on `op_kind` or `op_wdata` without `op_start` have no effect on later reads.
- R8: `rd_valid` is high for exactly one cycle, the cycle in which `rd_data` holds a freshly loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse: a new internal operation begins |
| op_kind | input | 1 | 0 = program, 1 = erase; sampled on `op_start` |
| op_wdata | input | DATA_W | Word being programmed; sampled on `op_start` |
| busy | input | 1 | Internal operation in progress |
| rd_en | input | 1 | Read enable level; each rising edge is one read |
| array_word | input | DATA_W | True data of the addressed location |
| rd_data | output | DATA_W | Registered word for the data bus |
| rd_valid | output | 1 | Pulse marking a freshly loaded `rd_data` |

## Verification
The bench builds the block with its default 16-bit word and status flags at bits 7 and 6.

It sweeps both values of the programmed bit 7 against a set of array patterns, and it sweeps erase operations across the same patterns. For each operation it makes runs of several reads. Both flag positions, their interaction with the surrounding pass-through bits, and the alternation sequence from a fresh start are therefore all in reach.

Reads with long enable pulses, a restart in the middle of an operation, and input changes without a start pulse cover the edge-counting and capture rules.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;
endpackage

// File: rtl/wsp_edge_detect.sv
module wsp_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/wsp_op_latch.sv
module wsp_op_latch #(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  wsp_pkg::op_kind_e     kind_in,
  input  logic [DATA_W-1:0]     wdata_in,
  output wsp_pkg::op_kind_e     kind_q,
  output logic [DATA_W-1:0]     wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= wsp_pkg::OP_PROGRAM;
      wdata_q <= '0;
    end else if (start) begin
      kind_q  <= kind_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/wsp_toggle_track.sv
module wsp_toggle_track (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  output logic tgl
);
  always_ff @(posedge clk) begin
    if (rst || clear) tgl <= 1'b0;
    else if (advance) tgl <= ~tgl;
  end
endmodule

// File: rtl/wsp_status_format.sv
module wsp_status_format #(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              busy,
  input  wsp_pkg::op_kind_e kind,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] array_word,
  input  logic              tgl,
  output logic [DATA_W-1:0] word
);
  logic is_erase;
  assign is_erase = (kind == wsp_pkg::OP_ERASE);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign word[i] = busy ? (is_erase ? 1'b0 : ~wdata[i]) : array_word[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign word[i] = busy ? tgl : array_word[i];
    end else begin : g_pass
      assign word[i] = (busy && is_erase) ? 1'b1 : array_word[i];
    end
  end
endmodule

// File: rtl/write_status_poll.sv
module write_status_poll #(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic              op_kind,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              busy,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] array_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              rd_rise;
  logic              tgl_q;
  wsp_pkg::op_kind_e kind_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] word_next;

  wsp_edge_detect u_edge (
    .clk(clk), .rst(rst), .level(rd_en), .rise(rd_rise)
  );

  wsp_op_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .start(op_start),
    .kind_in(wsp_pkg::op_kind_e'(op_kind)), .wdata_in(op_wdata),
    .kind_q(kind_q), .wdata_q(wdata_q)
  );

  wsp_toggle_track u_tgl (
    .clk(clk), .rst(rst), .clear(op_start),
    .advance(rd_rise & busy), .tgl(tgl_q)
  );

  wsp_status_format #(
    .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
  ) u_fmt (
    .busy(busy), .kind(kind_q), .wdata(wdata_q),
    .array_word(array_word), .tgl(tgl_q), .word(word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_rise;
      if (rd_rise) rd_data <= word_next;
    end
  end
endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              op_start,
  input logic              busy,
  input logic              rd_en,
  input logic [DATA_W-1:0] array_word,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              kind_q,
  input logic [DATA_W-1:0] wdata_q,
  input logic              tgl_q
);
  logic en_prev;
  logic fire;

  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b0;
    else     en_prev <= rd_en;
  end
  assign fire = rd_en && !en_prev;

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
    fire && busy && !kind_q && !op_start |=> rd_data[POLL_BIT] == ~$past(wdata_q[POLL_BIT])); // R1
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
    fire && busy && kind_q |=> rd_data[POLL_BIT] == 1'b0); // R2
  AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    fire && busy && !op_start |=> tgl_q != $past(tgl_q)); // R3
  AST_NO_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    !fire && !op_start |=> $stable(tgl_q)); // R4
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    fire && !busy |=> rd_data == $past(array_word)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(rd_data)); // R6
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !tgl_q); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R8
endmodule

bind write_status_poll wsp_checker #(
  .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
) u_chk (
  .clk(clk), .rst(rst), .op_start(op_start), .busy(busy), .rd_en(rd_en),
  .array_word(array_word), .rd_data(rd_data), .rd_valid(rd_valid),
  .kind_q(kind_q), .wdata_q(wdata_q), .tgl_q(tgl_q)
);

// File: tb/write_status_poll_bench.sv
module write_status_poll_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_start = 1'b0;
  logic         op_kind = 1'b0;
  logic [W-1:0] op_wdata = '0;
  logic         busy = 1'b0;
  logic         rd_en = 1'b0;
  logic [W-1:0] array_word = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;

  int n_vec = 0;
  int n_bad = 0;
  int rd_idx = 0;
  logic cur_erase = 1'b0;
  logic [W-1:0] cur_wdata = '0;

  always #4 clk = ~clk;

  write_status_poll u_write_status_poll (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_wdata(op_wdata), .busy(busy), .rd_en(rd_en),
    .array_word(array_word), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] status_exp(input logic [W-1:0] arr, input int idx);
    logic [W-1:0] e;
    if (cur_erase) begin
      e = '1;
      e[7] = 1'b0;
    end else begin
      e = arr;
      e[7] = ~cur_wdata[7];
    end
    e[6] = (idx % 2 == 1);
    return e;
  endfunction

  task automatic start_op(input logic erase, input logic [W-1:0] wd);
    @(negedge clk);
    op_start = 1'b1; op_kind = erase; op_wdata = wd; busy = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    op_kind = ~erase; op_wdata = ~wd;   // R7: changes without a start pulse
    cur_erase = erase; cur_wdata = wd; rd_idx = 0;
  endtask

  task automatic do_read(input string req, input logic [W-1:0] exp, input int hold);
    rd_en = 1'b1;
    @(negedge clk);
    check(req, rd_data, exp);
    check("R8", {{(W-1){1'b0}}, rd_valid}, {{(W-1){1'b0}}, 1'b1});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R4", rd_data, exp);
      check("R8", {{(W-1){1'b0}}, rd_valid}, '0);
    end
    rd_en = 1'b0;
    @(negedge clk);
    check("R6", rd_data, exp);
  endtask

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
    pats[3] = 16'h5A3C; pats[4] = 16'h0080; pats[5] = 16'hFF7F;

    repeat (3) @(negedge clk);
    check("R6", rd_data, '0);
    check("R6", {{(W-1){1'b0}}, rd_valid}, '0);
    rst = 1'b0;

    // R1 and R3: program sweep
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < 6; p++) begin
        start_op(1'b0, pats[(p + 2) % 6] ^ (b == 1 ? 16'h0080 : 16'h0000));
        array_word = pats[p];
        for (int r = 0; r < 4; r++) begin
          do_read((r < 2) ? "R3" : "R1", status_exp(array_word, rd_idx), r % 3);
          rd_idx++;
        end
        busy = 1'b0;
        do_read("R5", array_word, 0);
      end
    end

    // R2: erase sweep
    for (int p = 0; p < 6; p++) begin
      start_op(1'b1, pats[p]);
      array_word = pats[5 - p];
      for (int r = 0; r < 3; r++) begin
        do_read("R2", status_exp(array_word, rd_idx), r);
        rd_idx++;
      end
      busy = 1'b0;
      array_word = 16'hFFFF;
      do_read("R5", 16'hFFFF, 0);
    end

    // R7: restart mid-operation clears toggle
    start_op(1'b0, 16'h1234);
    array_word = 16'h0F0F;
    do_read("R3", status_exp(array_word, 0), 0);
    start_op(1'b1, 16'h0000);
    do_read("R7", status_exp(array_word, 0), 0);
    rd_idx = 1;
    do_read("R7", status_exp(array_word, 1), 0);
    busy = 1'b0;
    do_read("R5", array_word, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule